// File: doc/BRIEF.md
# Non-Maskable Interrupt Cause Latch with Software Board Reset

This block turns every non-maskable event on the board into one single-cycle NMI pulse to the processor and records why it fired. Two kinds of source feed it. One is the already debounced push-button level. The other is a vector of illegal-write error pulses, one from each bus target. All the error pulses are ORed together. A cause register holds two bits: an event flag, set by every NMI, and a write-error bit, set whenever any target reports an illegal write.

The cause register is cleared only by the cold reset and by a software acknowledge. The NMI restart does not clear it, and neither does the board reset that this block drives. After the restart, software reads the flag to tell an NMI restart (flag 1) from a cold start (flag 0). While an earlier NMI is still unacknowledged, the push-button is masked. Write errors are never masked.

The same register window holds a reset trigger. Writing a fixed key to it produces a board reset pulse of fixed length.

Top module: `nmi_ctrl_top`

## Requirements
- R1: After the synchronous reset, `nmi_pulse` and `board_rst` are 0 and the cause register at offset 0x40 reads 0.
- R2: A pulse on any bit of `werr_in` gives `nmi_pulse` high for exactly the following cycle, and from then on offset 0x40 reads 0x3 (bit 0 is the event flag, bit 1 is the write-error bit).
- R3: With the cause register clear, a rising `btn_lvl` gives a one-cycle `nmi_pulse` in the following cycle, and offset 0x40 then reads 0x1.
- R4: While the event flag is 1, `btn_lvl` produces no NMI and leaves the cause register unchanged.
- R5: A write-error pulse while the event flag is already 1 still produces a new `nmi_pulse` and sets the write-error bit.
- R6: An NMI source that is held for several cycles produces only one `nmi_pulse` cycle. A new pulse needs the combined condition to fall and rise again.
- R7: A write to offset 0x48 with data bit 0 equal to 1 clears both cause bits by the next cycle. A write there with bit 0 equal to 0 has no effect.
- R8: If an NMI event and an acknowledge arrive in the same cycle, the event wins: the flag ends at 1, and the write-error bit ends at 1 if a write error took part.
- R9: The cause register keeps its value through a board reset pulse. Only the cold reset or an acknowledge changes it.
- R10: Writing 0x4D as the low data byte to offset 0x50 drives `board_rst` high for exactly 16 cycles, starting the cycle after the write.
- R11: A write of any other value to offset 0x50 leaves `board_rst` low. A write of 0x4D to any other offset does not trigger a board reset. Offsets other than 0x40 read 0, and the reserved bits 31:2 of 0x40 read 0.
- R12: A key write during an active board reset pulse restarts the full 16-cycle length, counted from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high cold reset |
| btn_lvl | input | 1 | Debounced push-button level |
| werr_in | input | NUM_SRC (4) | Illegal-write error pulses, one per bus target |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (12) | Register write byte offset |
| wr_data | input | 8 | Register write data, low byte |
| rd_addr | input | ADDR_W (12) | Register read byte offset |
| rd_data | output | DATA_W (32) | Read data for `rd_addr`, combinational |
| nmi_pulse | output | 1 | One-cycle NMI request to the CPU |
| board_rst | output | 1 | Board reset pulse |

## Verification
A wrong edge register shows up at the `nmi_pulse` port as a doubled or missing pulse, one cycle after the source changes. A cause bit that is set or cleared wrongly shows up in the very next read of offset 0x40, because the read path is combinational from the cause flops. Mistakes in the reset counter show up as a `board_rst` high time that differs from 16 cycles, or from the restarted length when the key is written again. The bench measures that high time cycle by cycle.

// File: rtl/nmi_ctrl_pkg.sv
package nmi_ctrl_pkg;

    localparam logic [31:0] OFS_CAUSE = 32'h40;
    localparam logic [31:0] OFS_ACK   = 32'h48;
    localparam logic [31:0] OFS_BRST  = 32'h50;
    localparam logic [7:0]  BRST_KEY  = 8'h4D;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_ACK,
        SEL_BRST
    } reg_sel_e;

    // bit 0: event flag, bit 1: write-error
    typedef struct packed {
        logic werr;
        logic flag;
    } cause_t;

    function automatic reg_sel_e decode_sel(input logic [31:0] ofs);
        reg_sel_e s;
        if (ofs == OFS_CAUSE)      s = SEL_CAUSE;
        else if (ofs == OFS_ACK)   s = SEL_ACK;
        else if (ofs == OFS_BRST)  s = SEL_BRST;
        else                       s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/nmi_event_gen.sv
module nmi_event_gen #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               btn_lvl,
    input  logic [NUM_SRC-1:0] werr_in,
    input  logic               flag_q,
    output logic               set_ev,
    output logic               werr_any,
    output logic               nmi_pulse
);

    logic cond;
    logic cond_q;

    assign werr_any = |werr_in;
    // button is masked while a previous event is unacknowledged
    assign cond     = (btn_lvl & ~flag_q) | werr_any;
    assign set_ev   = cond & ~cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q    <= 1'b0;
            nmi_pulse <= 1'b0;
        end else begin
            cond_q    <= cond;
            nmi_pulse <= set_ev;
        end
    end

    assert_nmi_single_R6: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |=> !nmi_pulse);

    assert_btn_masked_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !werr_any) |=> !nmi_pulse);

endmodule

// File: rtl/nmi_cause_reg.sv
module nmi_cause_reg
    import nmi_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   set_ev,
    input  logic   werr_any,
    input  logic   ack_clr,
    output cause_t cause_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            if (ack_clr) cause_q <= '0;
            // a new event overrides a same-cycle acknowledge
            if (set_ev)   cause_q.flag <= 1'b1;
            if (werr_any) cause_q.werr <= 1'b1;
        end
    end

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_clr && !set_ev && !werr_any) |=> (cause_q == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> cause_q.flag);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!ack_clr && !set_ev && !werr_any) |=> $stable(cause_q));

endmodule

// File: rtl/board_reset_gen.sv
module board_reset_gen #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic board_rst
);

    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (trig)         cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign board_rst = (cnt_q != '0);

    assert_key_starts_R10: assert property (@(posedge clk) disable iff (rst)
        trig |=> board_rst);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!trig && !board_rst) |=> !board_rst);

    assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD);

endmodule

// File: rtl/nmi_ctrl_top.sv
module nmi_ctrl_top
    import nmi_ctrl_pkg::*;
#(
    parameter int NUM_SRC   = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int PULSE_LEN = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               btn_lvl,
    input  logic [NUM_SRC-1:0] werr_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               nmi_pulse,
    output logic               board_rst
);

    localparam int RSV_W = DATA_W - $bits(cause_t);

    reg_sel_e wsel;
    reg_sel_e rsel;
    cause_t   cause_q;
    logic     set_ev;
    logic     werr_any;
    logic     ack_clr;
    logic     brst_trig;

    assign wsel      = decode_sel(32'(wr_addr));
    assign rsel      = decode_sel(32'(rd_addr));
    assign ack_clr   = wr_en && (wsel == SEL_ACK) && wr_data[0];
    assign brst_trig = wr_en && (wsel == SEL_BRST) && (wr_data == BRST_KEY);

    nmi_event_gen #(.NUM_SRC(NUM_SRC)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .btn_lvl   (btn_lvl),
        .werr_in   (werr_in),
        .flag_q    (cause_q.flag),
        .set_ev    (set_ev),
        .werr_any  (werr_any),
        .nmi_pulse (nmi_pulse)
    );

    nmi_cause_reg u_cause (
        .clk      (clk),
        .rst      (rst),
        .set_ev   (set_ev),
        .werr_any (werr_any),
        .ack_clr  (ack_clr),
        .cause_q  (cause_q)
    );

    board_reset_gen #(.PULSE_LEN(PULSE_LEN)) u_brst (
        .clk       (clk),
        .rst       (rst),
        .trig      (brst_trig),
        .board_rst (board_rst)
    );

    always_comb begin
        rd_data = '0;
        if (rsel == SEL_CAUSE) rd_data = {{RSV_W{1'b0}}, cause_q};
    end

    assert_nmi_flag_R2: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |-> cause_q.flag);

    assert_rsv_zero_R11: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-1:2] == '0);

endmodule

// File: tb/nmi_ctrl_top_tb_top.sv
module nmi_ctrl_top_tb_top;

    localparam int NS = 4;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          btn_lvl = 1'b0;
    logic [NS-1:0] werr_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = 12'h040;
    logic [DW-1:0] rd_data;
    logic          nmi_pulse;
    logic          board_rst;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    nmi_ctrl_top dut_i (
        .clk(clk), .rst(rst), .btn_lvl(btn_lvl), .werr_in(werr_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .nmi_pulse(nmi_pulse), .board_rst(board_rst)
    );

    // {btn, werr[3:0], ack_wr, ack_bit0, exp_nmi, exp_cause[1:0]}
    localparam int NV = 19;
    localparam logic [9:0] VEC [NV] = '{
        10'b0_0000_0_0_0_00,
        10'b1_0000_0_0_1_01,
        10'b1_0000_0_0_0_01,
        10'b0_0000_0_0_0_01,
        10'b1_0000_0_0_0_01,
        10'b0_0000_1_0_0_01,
        10'b0_0000_1_1_0_00,
        10'b0_0100_0_0_1_11,
        10'b0_0100_0_0_0_11,
        10'b0_0000_0_0_0_11,
        10'b0_0001_0_0_1_11,
        10'b0_0000_1_1_0_00,
        10'b1_0000_1_1_1_01,
        10'b0_0000_1_1_0_00,
        10'b0_1000_1_1_1_11,
        10'b0_0000_1_1_0_00,
        10'b1_0010_0_0_1_11,
        10'b0_0000_0_0_0_11,
        10'b0_0000_1_1_0_00
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:  return "R1";
            1:  return "R3";
            2:  return "R6";
            3, 4: return "R4";
            7, 9, 17: return "R2";
            8:  return "R6";
            10, 16: return "R5";
            12, 14: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        btn_lvl = 1'b0; werr_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic write(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        int n;
        @(negedge clk);
        btn_lvl = 1'b1; werr_in = 4'hF;
        step(); step(); step();
        idle();
        rst = 1'b0;
        // R1 reset state
        check("R1 nmi", 32'(nmi_pulse), 0);
        check("R1 brst", 32'(board_rst), 0);
        check("R1 cause", rd_data, 0);

        for (int i = 0; i < NV; i++) begin
            btn_lvl = VEC[i][9];
            werr_in = VEC[i][8:5];
            wr_en   = VEC[i][4];
            wr_addr = 12'h048;
            wr_data = {7'b0, VEC[i][3]};
            step();
            idle();
            check({vec_tag(i), " nmi"}, 32'(nmi_pulse), 32'(VEC[i][2]));
            check({vec_tag(i), " cause"}, rd_data, 32'(VEC[i][1:0]));
        end

        // R11: other offsets read zero while the cause is set
        werr_in = 4'h2; step(); idle();
        check("R11 cause set", rd_data, 3);
        rd_addr = 12'h048; #1; check("R11 rd ack ofs", rd_data, 0);
        rd_addr = 12'h050; #1; check("R11 rd brst ofs", rd_data, 0);
        rd_addr = 12'h044; #1; check("R11 rd gap ofs", rd_data, 0);
        rd_addr = 12'h040;
        // R11: wrong key to reset register
        write(12'h050, 8'h4C); step(); idle();
        check("R11 wrong key", 32'(board_rst), 0);
        step();
        check("R11 wrong key later", 32'(board_rst), 0);
        check("R11 cause kept", rd_data, 3);
        // R11: key value to the acknowledge offset does not reset (but acks)
        write(12'h048, 8'h4D); step(); idle();
        check("R11 key at ack", 32'(board_rst), 0);
        check("R7 ack by key value", rd_data, 0);

        // R10 / R9: exact pulse length, cause kept across it
        werr_in = 4'h8; step(); idle();
        check("R9 cause before", rd_data, 3);
        write(12'h050, 8'h4D); step(); idle();
        n = 0;
        while (board_rst && n < 60) begin n++; step(); end
        check("R10 pulse length", n, 16);
        check("R9 cause after", rd_data, 3);

        // R12: retrigger restarts the length
        write(12'h050, 8'h4D); step(); idle();
        n = 0;
        while (board_rst && n < 60) begin
            if (n == 5) write(12'h050, 8'h4D); else idle();
            n++;
            step();
        end
        idle();
        check("R12 restarted length", n, 22);

        // R1 again: cold reset clears the cause
        rst = 1'b1; step(); rst = 1'b0;
        check("R1 cause cleared", rd_data, 0);

        finish_run();
    end

endmodule